// File: doc/BRIEF.md
# Prioritized Interrupt Controller

This block collects interrupt requests from a set of on-chip peripheral lines and four external request pins and turns them into one standard interrupt request for the processor. One further external pin is the only path to a separate fast interrupt request. The fast path carries no arbitration. External pins reach the rest of the logic through a two-flop synchronizer.

Each standard source has its own configuration: an enable bit, a 3-bit priority and a trigger mode. The block shows the highest-priority eligible source on `cur_src_o`/`cur_prio_o`. Software acknowledges that source with a one-cycle `ack_i` pulse, which models the read of a current-source register. The acknowledge clears a latched edge and pushes the source's priority onto a small stack. While a priority is on the stack, only strictly higher priorities can raise the standard request again. A pulse on `eoi_i` pops the stack and restores the level that was active before.

Source numbering: internal sources are 0 to N_INT-1, and external pins follow as N_INT to N_INT+N_EXT-1. With the default parameters these are sources 0–3 (internal) and 4–7 (external pins 0–3).

Top module: `irq_prio_ctrl`

## Requirements
- R1: `fiq_o` equals `ext_fiq_i` delayed by exactly two clock edges. No standard source has any influence on it.
- R2: `irq_o` is high exactly when at least one enabled, pending source is eligible. In that case `cur_src_o` names a source that is both enabled and pending.
- R3: Among eligible sources, the one with the numerically highest priority (0 to 7) wins. On equal priority, the lower source number wins. `cur_prio_o` shows the winner's priority.
- R4: Internal sources use bit 1 of the mode as the trigger selector. A value of 0 selects active-high level, where the source is pending while its input is high. A value of 1 selects rising edge, where the edge is latched. Bit 0 has no effect on internal sources.
- R5: External sources use the 2-bit mode 00 = high level, 01 = low level, 10 = rising edge, 11 = falling edge. Each is evaluated on the synchronized pin, so a level is seen two edges after the pin changes and a latched edge three edges after.
- R6: A latched edge stays pending after its input returns until the source is acknowledged, and the acknowledge clears it. A level source is never latched and stops pending when its input goes inactive.
- R7: A disabled source never raises `irq_o` or wins arbitration. It still latches edges, so enabling it later raises `irq_o` with no new edge.
- R8: An acknowledge taken while `irq_o` is high pushes the winner's priority. After that, only sources with a strictly higher priority than the top of the stack are eligible.
- R9: An `eoi_i` pulse pops the stack. Eligibility then returns to the previous stacked priority, or to no threshold when the stack becomes empty.
- R10: When the stack holds STACK_DEPTH entries (default 4), no source is eligible until an `eoi_i` pulse.
- R11: After reset, all sources are disabled with priority 0 and high-level mode, the stack is empty, and `irq_o` and `fiq_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| int_req_i | input | N_INT | Internal peripheral request lines (synchronous) |
| ext_irq_i | input | N_EXT | External standard request pins (asynchronous) |
| ext_fiq_i | input | 1 | External fast request pin (asynchronous) |
| cfg_we_i | input | 1 | Write strobe for one source's configuration |
| cfg_sel_i | input | SRC_W | Source number being configured |
| cfg_en_i | input | 1 | Enable value to write |
| cfg_prio_i | input | PRIO_W | Priority value to write |
| cfg_mode_i | input | 2 | Trigger mode value to write |
| ack_i | input | 1 | Acknowledge (current-source read) pulse |
| eoi_i | input | 1 | End-of-interrupt pulse |
| fiq_o | output | 1 | Fast interrupt request to the processor |
| irq_o | output | 1 | Standard interrupt request to the processor |
| cur_src_o | output | SRC_W | Number of the winning source |
| cur_prio_o | output | PRIO_W | Priority of the winning source |

## Verification
The assertions check four properties on every cycle. The fast output rises only after the fast pin was high two edges earlier. A raised request always names an enabled, pending source that strictly beats the stacked level. The stack never exceeds its depth, and a full stack holds the request low. Latched edges clear on acknowledge and otherwise persist. Some behaviour needs the bench's scenarios to show: the tie-break by source number, the four external trigger modes seen through the synchronizer, edges recorded while a source is disabled, and the restore of earlier levels as end-of-interrupt unwinds a nested sequence.

// File: rtl/irq_pkg.sv
package irq_pkg;
  typedef enum logic [1:0] {
    TRIG_HIGH = 2'b00,
    TRIG_LOW  = 2'b01,
    TRIG_RISE = 2'b10,
    TRIG_FALL = 2'b11
  } trig_e;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/irq_src_cell.sv
module irq_src_cell
  import irq_pkg::*;
#(
  parameter bit IS_EXT = 1'b0
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  raw_i,
  input  trig_e mode_i,
  input  logic  ack_i,
  output logic  pend_o
);
  logic inv, lvl, edge_mode, edge_set;
  logic prev_q, prev_d;
  logic pend_q, pend_d;

  always_comb begin
    inv       = IS_EXT ? mode_i[0] : 1'b0;
    lvl       = raw_i ^ inv;
    edge_mode = mode_i[1];
    edge_set  = lvl & ~prev_q;
    prev_d    = lvl;
    if (!edge_mode)     pend_d = 1'b0;
    else if (edge_set)  pend_d = 1'b1;
    else if (ack_i)     pend_d = 1'b0;
    else                pend_d = pend_q;
    pend_o = edge_mode ? pend_q : lvl;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      prev_q <= prev_d;
      pend_q <= pend_d;
    end
  end

  // R6: an acknowledge with no new edge clears the latch
  p_edge_ack_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && edge_mode && !edge_set) |=> !pend_q);
  // R6: a latched edge persists until acknowledged
  p_edge_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_mode && pend_q && !ack_i) |=> (pend_q || !mode_i[1]));
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
  parameter int NSRC   = 8,
  parameter int PRIO_W = 3,
  localparam int SRC_W = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic [NSRC-1:0]             req_i,
  input  logic [NSRC-1:0][PRIO_W-1:0] prio_i,
  input  logic                        thr_valid_i,
  input  logic [PRIO_W-1:0]           thr_i,
  input  logic                        block_i,
  output logic                        hit_o,
  output logic [SRC_W-1:0]            src_o,
  output logic [PRIO_W-1:0]           prio_o
);
  logic [NSRC-1:0] elig;

  genvar g;
  generate
    for (g = 0; g < NSRC; g++) begin : g_elig
      assign elig[g] = req_i[g] && !block_i &&
                       (!thr_valid_i || (prio_i[g] > thr_i));
    end
  endgenerate

  always_comb begin
    hit_o  = 1'b0;
    src_o  = '0;
    prio_o = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (elig[i] && (!hit_o || (prio_i[i] > prio_o))) begin
        hit_o  = 1'b1;
        src_o  = SRC_W'(i);
        prio_o = prio_i[i];
      end
    end
  end
endmodule

// File: rtl/irq_prio_stack.sv
module irq_prio_stack #(
  parameter int DEPTH  = 4,
  parameter int PRIO_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_i,
  input  logic              pop_i,
  input  logic [PRIO_W-1:0] din_i,
  output logic [PRIO_W-1:0] top_o,
  output logic              nonempty_o,
  output logic              full_o
);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [PRIO_W-1:0] mem_q [DEPTH];
  logic [CNT_W-1:0]  cnt_q, cnt_d, wr_idx;
  logic [IDX_W-1:0]  top_idx;
  logic              do_push, do_pop;

  always_comb begin
    nonempty_o = (cnt_q != '0);
    full_o     = (cnt_q == CNT_W'(DEPTH));
    do_pop     = pop_i && nonempty_o;
    do_push    = push_i && (!full_o || do_pop);
    cnt_d      = cnt_q + CNT_W'(do_push) - CNT_W'(do_pop);
    wr_idx     = do_pop ? (cnt_q - CNT_W'(1)) : cnt_q;
    top_idx    = IDX_W'(cnt_q - CNT_W'(1));
    top_o      = nonempty_o ? mem_q[top_idx] : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  genvar e;
  generate
    for (e = 0; e < DEPTH; e++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                 mem_q[e] <= '0;
        else if (do_push && (wr_idx == CNT_W'(e)))  mem_q[e] <= din_i;
      end
    end
  endgenerate

  p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(DEPTH));
  p_pop_restores_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_i && !push_i && nonempty_o) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irq_pkg::*;
#(
  parameter int N_INT       = 4,
  parameter int N_EXT       = 4,
  parameter int PRIO_W      = 3,
  parameter int STACK_DEPTH = 4,
  localparam int NSRC  = N_INT + N_EXT,
  localparam int SRC_W = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_INT-1:0]  int_req_i,
  input  logic [N_EXT-1:0]  ext_irq_i,
  input  logic              ext_fiq_i,
  input  logic              cfg_we_i,
  input  logic [SRC_W-1:0]  cfg_sel_i,
  input  logic              cfg_en_i,
  input  logic [PRIO_W-1:0] cfg_prio_i,
  input  logic [1:0]        cfg_mode_i,
  input  logic              ack_i,
  input  logic              eoi_i,
  output logic              fiq_o,
  output logic              irq_o,
  output logic [SRC_W-1:0]  cur_src_o,
  output logic [PRIO_W-1:0] cur_prio_o
);
  logic [N_EXT:0]                sync_q;
  logic [NSRC-1:0]               raw, pend, req;
  logic [NSRC-1:0]               en_q, en_d;
  logic [NSRC-1:0][PRIO_W-1:0]   prio_q, prio_d;
  trig_e                         mode_q [NSRC];
  trig_e                         mode_d [NSRC];
  logic                          push, pop;
  logic [PRIO_W-1:0]             stk_top;
  logic                          stk_nonempty, stk_full;

  // synchronizer for external pins plus the fast pin in the top bit
  irq_sync #(.W(N_EXT + 1)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   ({ext_fiq_i, ext_irq_i}),
    .q_o   (sync_q)
  );

  assign fiq_o = sync_q[N_EXT];
  assign raw   = {sync_q[N_EXT-1:0], int_req_i};

  // configuration next-state
  always_comb begin
    en_d   = en_q;
    prio_d = prio_q;
    for (int i = 0; i < NSRC; i++) mode_d[i] = mode_q[i];
    if (cfg_we_i && (int'(cfg_sel_i) < NSRC)) begin
      en_d[cfg_sel_i]   = cfg_en_i;
      prio_d[cfg_sel_i] = cfg_prio_i;
      mode_d[cfg_sel_i] = trig_e'(cfg_mode_i);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      prio_q <= '0;
      for (int i = 0; i < NSRC; i++) mode_q[i] <= TRIG_HIGH;
    end else begin
      en_q   <= en_d;
      prio_q <= prio_d;
      for (int i = 0; i < NSRC; i++) mode_q[i] <= mode_d[i];
    end
  end

  assign push = ack_i && irq_o;
  assign pop  = eoi_i;

  genvar g;
  generate
    for (g = 0; g < NSRC; g++) begin : g_src
      irq_src_cell #(.IS_EXT(g >= N_INT)) u_cell (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_i  (raw[g]),
        .mode_i (mode_q[g]),
        .ack_i  (push && (cur_src_o == SRC_W'(g))),
        .pend_o (pend[g])
      );
    end
  endgenerate

  assign req = pend & en_q;

  irq_arbiter #(.NSRC(NSRC), .PRIO_W(PRIO_W)) u_arb (
    .req_i       (req),
    .prio_i      (prio_q),
    .thr_valid_i (stk_nonempty),
    .thr_i       (stk_top),
    .block_i     (stk_full),
    .hit_o       (irq_o),
    .src_o       (cur_src_o),
    .prio_o      (cur_prio_o)
  );

  irq_prio_stack #(.DEPTH(STACK_DEPTH), .PRIO_W(PRIO_W)) u_stk (
    .clk        (clk),
    .rst_n      (rst_n),
    .push_i     (push),
    .pop_i      (pop),
    .din_i      (cur_prio_o),
    .top_o      (stk_top),
    .nonempty_o (stk_nonempty),
    .full_o     (stk_full)
  );

  p_fiq_from_pin_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fiq_o) |-> $past(ext_fiq_i, 2));
  p_winner_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (en_q[cur_src_o] && pend[cur_src_o]));
  p_nest_strict_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && stk_nonempty) |-> (cur_prio_o > stk_top));
  p_full_blocks_r10: assert property (@(posedge clk) disable iff (!rst_n)
    stk_full |-> !irq_o);
endmodule

// File: tb/sim_irq_prio_ctrl.sv
module sim_irq_prio_ctrl;
  localparam int N_INT = 4, N_EXT = 4, PRIO_W = 3, NSRC = 8, SRC_W = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N_INT-1:0]  int_req = '0;
  logic [N_EXT-1:0]  ext_irq = '0;
  logic              ext_fiq = 1'b0;
  logic              cfg_we = 1'b0;
  logic [SRC_W-1:0]  cfg_sel = '0;
  logic              cfg_en = 1'b0;
  logic [PRIO_W-1:0] cfg_prio = '0;
  logic [1:0]        cfg_mode = '0;
  logic              ack = 1'b0, eoi = 1'b0;
  logic              fiq, irq;
  logic [SRC_W-1:0]  cur_src;
  logic [PRIO_W-1:0] cur_prio;

  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  irq_prio_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .int_req_i(int_req), .ext_irq_i(ext_irq),
    .ext_fiq_i(ext_fiq), .cfg_we_i(cfg_we), .cfg_sel_i(cfg_sel),
    .cfg_en_i(cfg_en), .cfg_prio_i(cfg_prio), .cfg_mode_i(cfg_mode),
    .ack_i(ack), .eoi_i(eoi), .fiq_o(fiq), .irq_o(irq),
    .cur_src_o(cur_src), .cur_prio_o(cur_prio)
  );

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic cfg(int idx, bit en, int pr, int md);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = SRC_W'(idx); cfg_en = en;
    cfg_prio = PRIO_W'(pr); cfg_mode = 2'(md);
    @(negedge clk);
    cfg_we = 1'b0;
    #1;
  endtask

  task automatic do_ack();
    @(negedge clk); ack = 1'b1;
    @(negedge clk); ack = 1'b0;
    #1;
  endtask

  task automatic do_eoi();
    @(negedge clk); eoi = 1'b1;
    @(negedge clk); eoi = 1'b0;
    #1;
  endtask

  task automatic clear_cfg();
    for (int i = 0; i < NSRC; i++) cfg(i, 1'b0, 0, 0);
  endtask

  // expected winner among internal level sources: highest prio, lowest index
  function automatic int exp_win(logic [3:0] r, logic [3:0] e, int p[4]);
    int best = -1;
    for (int i = 0; i < 4; i++)
      if (r[i] && e[i] && (best < 0 || p[i] > p[best])) best = i;
    return best;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL R11 watchdog actual=timeout expected=finish");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int p[4];
    logic [3:0] e;
    int w;
    void'($urandom(32'd4242));
    step(3);
    rst_n = 1'b1;
    step(1);
    // R11 reset state
    chk("R11 irq after reset", irq, 0);
    chk("R11 fiq after reset", fiq, 0);
    int_req = 4'hF; step(1);
    chk("R11 sources disabled at reset", irq, 0);
    int_req = '0;

    // R3 R4 random arbitration over internal level sources, incl. ties
    for (int it = 0; it < 120; it++) begin
      e = 4'($urandom);
      for (int i = 0; i < 4; i++) begin
        p[i] = int'($urandom % 8);
        cfg(i, e[i], p[i], int'($urandom % 2)); // bit0 ignored internally
      end
      int_req = 4'($urandom);
      step(1);
      w = exp_win(int_req, e, p);
      chk("R2 irq vs enabled pending", irq, (w >= 0) ? 1 : 0);
      if (w >= 0) begin
        chk("R3 winner source", cur_src, w);
        chk("R3 winner prio", cur_prio, p[w]);
      end
    end
    int_req = '0;
    clear_cfg();

    // R1 fast pin path, unaffected by standard sources
    cfg(0, 1'b1, 7, 0);
    int_req[0] = 1'b1; step(3);
    chk("R1 fiq not driven by standard source", fiq, 0);
    chk("R2 standard request present", irq, 1);
    ext_fiq = 1'b1; step(1);
    chk("R1 fiq one edge after pin", fiq, 0);
    step(1);
    chk("R1 fiq two edges after pin", fiq, 1);
    ext_fiq = 1'b0; step(2);
    chk("R1 fiq drops", fiq, 0);
    int_req = '0;
    clear_cfg();

    // R4 R6 internal rising edge latch and ack clear
    cfg(0, 1'b1, 2, 2);
    int_req[0] = 1'b1; step(1);
    int_req[0] = 1'b0; step(1);
    chk("R6 edge latched after input low", irq, 1);
    chk("R4 edge source number", cur_src, 0);
    do_ack();
    chk("R6 ack clears edge", irq, 0);
    do_eoi();
    chk("R6 stays clear after eoi", irq, 0);

    // R7 disabled source records edge
    cfg(1, 1'b0, 1, 2);
    int_req[1] = 1'b1; step(1);
    int_req[1] = 1'b0; step(2);
    chk("R7 disabled gives no irq", irq, 0);
    cfg(1, 1'b1, 1, 2);
    chk("R7 enable exposes latched edge", irq, 1);
    chk("R7 source is 1", cur_src, 1);
    do_ack(); do_eoi();
    clear_cfg();

    // R5 external low level
    cfg(4, 1'b1, 5, 1);
    step(3);
    chk("R5 low-level pending", irq, 1);
    chk("R5 low-level source", cur_src, 4);
    ext_irq[0] = 1'b1; step(1);
    chk("R5 synchronizer delay", irq, 1);
    step(2);
    chk("R5 low-level released", irq, 0);
    ext_irq[0] = 1'b0;
    cfg(4, 1'b0, 0, 0);
    // R5 external rising
    cfg(5, 1'b1, 3, 2);
    ext_irq[1] = 1'b1; step(4);
    ext_irq[1] = 1'b0; step(4);
    chk("R5 rising latched", irq, 1);
    chk("R5 rising source", cur_src, 5);
    do_ack();
    chk("R6 ext ack clears", irq, 0);
    do_eoi();
    // R5 external falling
    ext_irq[2] = 1'b1; step(3);
    cfg(6, 1'b1, 4, 3);
    step(3);
    chk("R5 falling no edge yet", irq, 0);
    ext_irq[2] = 1'b0; step(4);
    chk("R5 falling latched", irq, 1);
    chk("R5 falling source", cur_src, 6);
    do_ack(); do_eoi();
    // R5 external high level
    cfg(7, 1'b1, 1, 0);
    ext_irq[3] = 1'b1; step(4);
    chk("R5 high-level pending", cur_src, 7);
    ext_irq[3] = 1'b0; step(3);
    chk("R6 level not latched", irq, 0);
    clear_cfg();

    // R8 R9 nesting
    cfg(2, 1'b1, 3, 0);
    cfg(3, 1'b1, 6, 0);
    int_req[2] = 1'b1; step(1);
    chk("R8 first source", cur_src, 2);
    do_ack();
    chk("R8 same prio masked", irq, 0);
    int_req[3] = 1'b1; step(1);
    chk("R8 higher prio preempts", irq, 1);
    chk("R8 higher source", cur_src, 3);
    do_ack();
    chk("R8 masked at level 6", irq, 0);
    do_eoi();
    chk("R9 restore level 3", irq, 1);
    chk("R9 src 3 again", cur_src, 3);
    int_req[3] = 1'b0; step(1);
    chk("R9 level 3 masks src 2", irq, 0);
    do_eoi();
    chk("R9 empty stack releases", irq, 1);
    chk("R9 src 2 again", cur_src, 2);
    int_req = '0;
    clear_cfg();

    // R10 stack full
    for (int i = 0; i < 4; i++) begin
      cfg(i, 1'b1, i + 1, 0);
    end
    for (int i = 0; i < 4; i++) begin
      int_req[i] = 1'b1; step(1);
      chk("R8 nested winner", cur_src, i);
      do_ack();
    end
    cfg(7, 1'b1, 7, 0);
    ext_irq[3] = 1'b1; step(4);
    chk("R10 full stack blocks", irq, 0);
    do_eoi();
    chk("R10 after pop irq", irq, 1);
    chk("R10 after pop source", cur_src, 7);
    ext_irq[3] = 1'b0; int_req = '0;
    do_eoi(); do_eoi(); do_eoi();
    step(3);
    chk("R9 all released", irq, 0);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule